// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This block carries a programmable logic device from the moment its supply is reported good to the point where its configuration bitstream has been fully received. First it waits out a power-on delay whose length depends on the selected configuration mode. Next it erases configuration memory one frame at a time. It then takes part in a shared open-drain INIT handshake, latches the mode pins again, and shifts in a serial bitstream of fixed length.

When the block is the clock master, it generates its own configuration clock. That clock starts slow and changes to a fast rate only if a rate-enable bit at a fixed header position arrives as 1. When the block is a clock slave, it takes data on rising edges of an external clock and watches that clock for a stall. All timing runs on the system clock `clk`, and every delay is a cycle-count parameter.

The states are `ST_POR_WAIT`, `ST_CLEAR`, `ST_INIT_WAIT`, `ST_SAMPLE_MODE`, `ST_LOAD` and `ST_DONE`, taken in that order:
- POR_WAIT→CLEAR when the power-on count expires.
- CLEAR→INIT_WAIT after the last frame.
- INIT_WAIT→SAMPLE_MODE when the INIT line is high and, in master mode, the resample wait has elapsed.
- SAMPLE_MODE→LOAD after one cycle.
- LOAD→DONE when the last bit is taken.
- Any state→POR_WAIT whenever `pwr_good` is low.

Top module: `cfg_load_seq`

## Requirements
- R1: When `pwr_good` is low at a clock edge, then after that edge the block is back in its power-on wait: `init_drive_low`=1, `done`=0, `err`=0 and `bits_loaded`=0.
- R2: Mode pins value 2'b00 selects master mode, with a power-on wait of `POR_MASTER_CYC` cycles. Any other value selects a clock-slave mode, with a wait of `POR_SLAVE_CYC` cycles.
- R3: Memory clearing takes `FRAMES`×`FRAME_CYC` cycles. `init_drive_low` is 1 from the rise of `pwr_good` through clearing, so it falls exactly power-on wait plus clear time edges after `pwr_good` rises.
- R4: While another device holds the INIT line low (`init_in`=0) after the block releases it, no configuration clock appears and no bit is taken.
- R5: In master mode, the first rising edge of `cclk_out` comes `RESAMPLE_CYC`+1+`SLOW_HALF` edges after the INIT release if no other device holds the line. If the line is released late by another device, it comes 2+`SLOW_HALF` edges after that release.
- R6: In master mode, the configuration clock starts with a period of 2×`SLOW_HALF` cycles. Data is taken on its rising edge.
- R7: The bit at 0-based index `RATE_BIT_POS`, in receive order, is the rate-enable bit. If it is 1, later periods are 2×`FAST_HALF` cycles. If it is 0, the clock stays at 2×`SLOW_HALF`.
- R8: In slave mode, one bit is taken per rising edge of `ext_cclk`, and `cclk_out` stays 0.
- R9: `done` rises once `BIT_COUNT` bits are taken, and `bits_loaded` then equals `BIT_COUNT`. Further clock edges change neither.
- R10: In slave-mode LOAD, if `ext_cclk` shows no rising edge for `EXT_TIMEOUT` cycles, `err` goes to 1 and stays there until `pwr_good` falls. No further bits are taken and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply reported good |
| mode | input | 2 | Mode pins; 2'b00 is master |
| init_in | input | 1 | Level of the shared open-drain INIT line |
| din | input | 1 | Serial configuration data |
| ext_cclk | input | 1 | External configuration clock for slave mode |
| init_drive_low | output | 1 | 1 pulls the INIT line low |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| bits_loaded | output | $clog2(BIT_COUNT+1) | Bits received so far |
| done | output | 1 | Bitstream fully received |
| err | output | 1 | External clock stalled during load |

## Verification
The bench measures the INIT release point in each mode. A design that used one power-on delay for all modes, or skipped a clear frame, misses the exact edge count. It holds the INIT line low from outside past the block's own release and times the first configuration clock edge. A design that ignored the wired-AND, or left out the master resample wait, starts clocking too early. It times clock periods before and after the rate-enable position with the bit at both 1 and 0, which catches an unconditional or misplaced speed switch. It also stalls the external clock mid-stream and drops power mid-load to check the sticky error and the full return to the power-on wait.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT    = 3'd0,
        ST_CLEAR       = 3'd1,
        ST_INIT_WAIT   = 3'd2,
        ST_SAMPLE_MODE = 3'd3,
        ST_LOAD        = 3'd4,
        ST_DONE        = 3'd5
    } cfg_state_e;

    localparam logic [1:0] MODE_MASTER = 2'b00;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
    parameter int SLOW_HALF = 8,
    parameter int FAST_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic cclk,
    output logic rise
);
    localparam int HW = $clog2(cfg_seq_pkg::imax(SLOW_HALF, FAST_HALF) + 1);

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] half_last;
    logic          cclk_q;
    logic          rise_q;

    assign half_last = fast ? HW'(FAST_HALF - 1) : HW'(SLOW_HALF - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
            rise_q <= 1'b0;
        end else if (!en) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
            rise_q <= 1'b0;
        end else if (cnt_q >= half_last) begin
            cnt_q  <= '0;
            cclk_q <= !cclk_q;
            rise_q <= !cclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            rise_q <= 1'b0;
        end
    end

    assign cclk = cclk_q;
    assign rise = rise_q;

    assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> cclk_q);

endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 3'b000;
        else        sync_q <= {sync_q[1:0], async_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cfg_bit_count.sv
module cfg_bit_count #(
    parameter int BIT_COUNT    = 24,
    parameter int RATE_BIT_POS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           strobe,
    input  logic                           din,
    output logic [$clog2(BIT_COUNT+1)-1:0] count,
    output logic                           fast
);
    localparam int CW = $clog2(BIT_COUNT + 1);

    logic [CW-1:0] count_q;
    logic          fast_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            fast_q  <= 1'b0;
        end else if (clr) begin
            count_q <= '0;
            fast_q  <= 1'b0;
        end else if (strobe && (count_q < CW'(BIT_COUNT))) begin
            count_q <= count_q + 1'b1;
            if ((count_q == CW'(RATE_BIT_POS)) && din) fast_q <= 1'b1;
        end
    end

    assign count = count_q;
    assign fast  = fast_q;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(BIT_COUNT));

    assert_fast_at_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_q) |-> ($past(count_q) == CW'(RATE_BIT_POS)));

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_seq_pkg::*;
#(
    parameter int POR_MASTER_CYC = 40,
    parameter int POR_SLAVE_CYC  = 10,
    parameter int FRAMES         = 4,
    parameter int FRAME_CYC      = 3,
    parameter int RESAMPLE_CYC   = 20,
    parameter int BIT_COUNT      = 24,
    parameter int RATE_BIT_POS   = 5,
    parameter int SLOW_HALF      = 8,
    parameter int FAST_HALF      = 2,
    parameter int EXT_TIMEOUT    = 40
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pwr_good,
    input  logic [1:0]                     mode,
    input  logic                           init_in,
    input  logic                           din,
    input  logic                           ext_cclk,
    output logic                           init_drive_low,
    output logic                           cclk_out,
    output logic [$clog2(BIT_COUNT+1)-1:0] bits_loaded,
    output logic                           done,
    output logic                           err
);
    localparam int TMAX = imax(imax(POR_MASTER_CYC, POR_SLAVE_CYC), imax(FRAME_CYC, RESAMPLE_CYC));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int FW   = $clog2(FRAMES + 1);
    localparam int IW   = $clog2(EXT_TIMEOUT + 1);
    localparam int CW   = $clog2(BIT_COUNT + 1);

    cfg_state_e    state_q, state_d;
    logic [TW-1:0] timer_q;
    logic [FW-1:0] frame_q;
    logic [IW-1:0] idle_q;
    logic [1:0]    mode_q;
    logic          err_q;
    logic          master_q;
    logic [TW-1:0] por_last;
    logic          gen_cclk, gen_rise, ext_rise, bit_fast, bit_strobe, bit_clr;
    logic [CW-1:0] bit_cnt;

    assign master_q = (mode_q == MODE_MASTER);
    assign por_last = master_q ? TW'(POR_MASTER_CYC - 1) : TW'(POR_SLAVE_CYC - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POR_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!pwr_good) begin
            state_d = ST_POR_WAIT;
        end else begin
            unique case (state_q)
                ST_POR_WAIT:
                    if (timer_q == por_last) state_d = ST_CLEAR;
                ST_CLEAR:
                    if ((frame_q == FW'(FRAMES - 1)) && (timer_q == TW'(FRAME_CYC - 1)))
                        state_d = ST_INIT_WAIT;
                ST_INIT_WAIT:
                    if (init_in && (!master_q || (timer_q >= TW'(RESAMPLE_CYC - 1))))
                        state_d = ST_SAMPLE_MODE;
                ST_SAMPLE_MODE:
                    state_d = ST_LOAD;
                ST_LOAD:
                    if (bit_cnt == CW'(BIT_COUNT)) state_d = ST_DONE;
                ST_DONE:
                    state_d = ST_DONE;
                default:
                    state_d = ST_POR_WAIT;
            endcase
        end
    end

    // timers, mode latch, stall watch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            frame_q <= '0;
            idle_q  <= '0;
            mode_q  <= MODE_MASTER;
            err_q   <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                timer_q <= '0;
                frame_q <= '0;
            end else begin
                unique case (state_q)
                    ST_POR_WAIT:  timer_q <= pwr_good ? timer_q + 1'b1 : '0;
                    ST_CLEAR: begin
                        if (timer_q == TW'(FRAME_CYC - 1)) begin
                            timer_q <= '0;
                            frame_q <= frame_q + 1'b1;
                        end else begin
                            timer_q <= timer_q + 1'b1;
                        end
                    end
                    ST_INIT_WAIT:
                        if (timer_q < TW'(RESAMPLE_CYC - 1)) timer_q <= timer_q + 1'b1;
                    default: ;
                endcase
            end

            if ((state_q == ST_POR_WAIT && timer_q == '0) || state_q == ST_SAMPLE_MODE)
                mode_q <= mode;

            if (state_q != ST_LOAD || ext_rise) idle_q <= '0;
            else if (idle_q < IW'(EXT_TIMEOUT - 1)) idle_q <= idle_q + 1'b1;

            if (!pwr_good)
                err_q <= 1'b0;
            else if (state_q == ST_LOAD && !master_q && idle_q >= IW'(EXT_TIMEOUT - 1))
                err_q <= 1'b1;
        end
    end

    assign bit_clr    = !pwr_good || state_q == ST_POR_WAIT || state_q == ST_SAMPLE_MODE;
    assign bit_strobe = (state_q == ST_LOAD) && !err_q && (master_q ? gen_rise : ext_rise);

    cfg_cclk_gen #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_cclk_gen (
        .clk(clk), .rst_n(rst_n),
        .en((state_q == ST_LOAD) && master_q),
        .fast(bit_fast), .cclk(gen_cclk), .rise(gen_rise)
    );

    cfg_edge_sync u_edge_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_cclk), .rise(ext_rise)
    );

    cfg_bit_count #(.BIT_COUNT(BIT_COUNT), .RATE_BIT_POS(RATE_BIT_POS)) u_bit_count (
        .clk(clk), .rst_n(rst_n), .clr(bit_clr), .strobe(bit_strobe),
        .din(din), .count(bit_cnt), .fast(bit_fast)
    );

    // outputs
    always_comb begin
        init_drive_low = (state_q == ST_POR_WAIT) || (state_q == ST_CLEAR);
        cclk_out       = (state_q == ST_LOAD) && master_q && gen_cclk;
        done           = (state_q == ST_DONE);
        err            = err_q;
        bits_loaded    = bit_cnt;
    end

    assert_pg_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (init_drive_low && !done && !err && bits_loaded == '0));

    assert_init_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && $past(state_q) == ST_SAMPLE_MODE) |-> $past(init_in, 2));

    assert_done_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (bits_loaded == CW'(BIT_COUNT)));

    assert_err_blocks_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done);

endmodule

// File: tb/cfg_load_seq_bench.sv
`timescale 1ns/100ps
module cfg_load_seq_bench;
    localparam int POR_M = 40, POR_S = 10, FR = 4, FC = 3, RS = 20;
    localparam int NB = 24, RPOS = 5, SH = 8, FH = 2, TO = 40;
    localparam int CW = $clog2(NB + 1);

    logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
    logic [1:0] mode = 2'b00;
    logic other_low = 1'b0, din = 1'b0, ext_cclk = 1'b0;
    logic init_drive_low, cclk_out, done, err, init_in;
    logic [CW-1:0] bits_loaded;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    int bits [64];

    assign init_in = !(init_drive_low || other_low);

    always #2.5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_load_seq #(.POR_MASTER_CYC(POR_M), .POR_SLAVE_CYC(POR_S), .FRAMES(FR),
        .FRAME_CYC(FC), .RESAMPLE_CYC(RS), .BIT_COUNT(NB), .RATE_BIT_POS(RPOS),
        .SLOW_HALF(SH), .FAST_HALF(FH), .EXT_TIMEOUT(TO)) u_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode(mode), .init_in(init_in),
        .din(din), .ext_cclk(ext_cclk), .init_drive_low(init_drive_low),
        .cclk_out(cclk_out), .bits_loaded(bits_loaded), .done(done), .err(err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_por(input logic [1:0] m);
        return ((m == 2'b00) ? POR_M : POR_S) + FR * FC;
    endfunction

    function automatic int exp_period(input bit fast);
        return fast ? 2 * FH : 2 * SH;
    endfunction

    task automatic cyc_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic make_bits(input int rate);
        for (int i = 0; i < NB; i++) bits[i] = int'($urandom & 1);
        bits[RPOS] = rate;
    endtask

    // power up and return edges until INIT is released
    task automatic power_up(input logic [1:0] m, output int n);
        pwr_good = 1'b0;
        mode = m;
        repeat (3) cyc_step();
        pwr_good = 1'b1;
        n = 0;
        while (1) begin
            cyc_step();
            n++;
            if (!init_drive_low || n > 2000) break;
        end
    endtask

    task automatic drop_power_check();
        pwr_good = 1'b0;
        cyc_step();
        check(init_drive_low && !done && !err && bits_loaded == 0, "R1 power drop",
              {init_drive_low, done, err}, 3'b100);
        check(bits_loaded == 0, "R1 count cleared", bits_loaded, 0);
    endtask

    task automatic master_run(input int rate, input bit hold);
        int n, bad, prev, idx, nr, guard;
        int rr [64];
        make_bits(rate);
        din = bits[0][0];
        other_low = hold;
        power_up(2'b00, n);
        check(n == exp_por(2'b00), "R2/R3 master INIT release", n, exp_por(2'b00));
        n = 0;
        if (hold) begin
            bad = 0;
            for (int i = 0; i < RS + 20; i++) begin
                cyc_step();
                if (cclk_out || bits_loaded != 0) bad++;
            end
            check(bad == 0, "R4 held INIT blocks load", bad, 0);
            other_low = 1'b0;
        end
        while (!cclk_out && n < 500) begin
            cyc_step();
            n++;
        end
        if (hold) check(n == 2 + SH, "R5 late release start", n, 2 + SH);
        else      check(n == RS + 1 + SH, "R5 resample wait", n, RS + 1 + SH);
        prev = 1; idx = 0; nr = 1; rr[0] = cyc; guard = 0;
        while (!done && guard < 3000) begin
            cyc_step();
            guard++;
            if (prev == 1 && !cclk_out) begin
                idx++;
                if (idx < NB) din = bits[idx][0];
            end
            if (prev == 0 && cclk_out && nr < 64) begin
                rr[nr] = cyc;
                nr++;
            end
            prev = int'(cclk_out);
        end
        check(rr[1] - rr[0] == exp_period(0), "R6 slow start period", rr[1] - rr[0], exp_period(0));
        check(rr[nr-1] - rr[nr-2] == exp_period(rate != 0), "R7 late period",
              rr[nr-1] - rr[nr-2], exp_period(rate != 0));
        check(done && bits_loaded == NB, "R9 master done count", bits_loaded, NB);
        repeat (20) cyc_step();
        check(done && bits_loaded == NB && !cclk_out, "R9 master hold after done", bits_loaded, NB);
        drop_power_check();
    endtask

    task automatic ext_bit(input int b, inout int bad);
        din = b[0];
        ext_cclk = 1'b0;
        repeat (5) begin cyc_step(); if (cclk_out) bad++; end
        ext_cclk = 1'b1;
        repeat (5) begin cyc_step(); if (cclk_out) bad++; end
    endtask

    task automatic slave_run(input bit stall);
        int n, bad;
        make_bits(1);
        ext_cclk = 1'b0;
        power_up(2'b11, n);
        check(n == exp_por(2'b11), "R2/R3 slave INIT release", n, exp_por(2'b11));
        repeat (3) cyc_step();
        bad = 0;
        if (!stall) begin
            for (int i = 0; i < NB; i++) ext_bit(bits[i], bad);
            repeat (6) cyc_step();
            check(bad == 0, "R8 slave cclk_out quiet", bad, 0);
            check(done && bits_loaded == NB, "R9 slave done count", bits_loaded, NB);
            for (int i = 0; i < 3; i++) ext_bit(1, bad);
            repeat (6) cyc_step();
            check(done && bits_loaded == NB, "R9 extra edges ignored", bits_loaded, NB);
        end else begin
            for (int i = 0; i < 6; i++) ext_bit(bits[i], bad);
            repeat (5) cyc_step();
            check(bits_loaded == 6, "R8 one bit per edge", bits_loaded, 6);
            repeat (TO - 15) cyc_step();
            check(!err, "R10 no early error", err, 0);
            repeat (20) cyc_step();
            check(err && !done, "R10 stall error", err, 1);
            ext_bit(1, bad);
            repeat (6) cyc_step();
            check(err && bits_loaded == 6, "R10 sticky, no capture", bits_loaded, 6);
        end
        drop_power_check();
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (4) cyc_step();
        check(init_drive_low && !done && !err && !cclk_out, "R1 reset state",
              {init_drive_low, done, err, cclk_out}, 4'b1000);
        check(bits_loaded == 0, "R1 reset count", bits_loaded, 0);
        rst_n = 1'b1;
        cyc_step();
        master_run(1, 1'b0);
        master_run(0, 1'b1);
        slave_run(1'b0);
        slave_run(1'b1);
        power_up(2'b01, n);
        check(n == exp_por(2'b01), "R2 other mode short wait", n, exp_por(2'b01));
        pwr_good = 1'b0;
        power_up(2'b10, n);
        pwr_good = 1'b0;
        cyc_step();
        check(init_drive_low && bits_loaded == 0, "R1 drop in CLEAR-free path", init_drive_low, 1);
        check(n == exp_por(2'b10), "R2 mode 2'b10 short wait", n, exp_por(2'b10));
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule